// File: doc/BRIEF.md
# Static Direction Branch Predictor

This block sits beside a simple fetch stage and guesses, with no learned history, whether each decoded conditional branch will be taken. For every instruction presented it returns a registered prediction and the address fetch should use next. The guess depends only on the branch itself. In the sequential policy every branch is guessed not taken. In the direction policy a branch whose target lies at or below its own address is guessed taken, because such a branch usually closes a loop. Any other branch is guessed not taken. A two-bit hint carried with the branch can force the guess either way in both policies.

Later in the pipe the real outcome of a branch comes back on the resolution inputs, together with the guess that was made for it. When the two differ, the block issues a one-cycle redirect with the corrected fetch address and a flush pulse. Any prediction presented in that same cycle comes from the wrong path and is dropped. Two saturating counters record how many branch predictions were issued and how many resolutions turned out wrong.

Top module: `static_branch_guess`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, out_taken, redirect_valid, flush and both counters are zero.
- R2: With mode = 0 and no active hint, a valid branch gives out_taken = 0 and out_next = in_pc + 4.
- R3: With mode = 1 and no active hint, a branch with in_target <= in_pc gives out_taken = 1 and out_next = in_target. A branch with in_target > in_pc gives out_taken = 0 and out_next = in_pc + 4.
- R4: Hint 2'b10 forces taken (out_next = in_target) and hint 2'b01 forces not taken (out_next = in_pc + 4), in either mode. Hints 2'b00 and 2'b11 leave the policy result unchanged.
- R5: A valid instruction with in_is_branch = 0 gives out_taken = 0 and out_next = in_pc + 4, whatever its target and hint.
- R6: A resolution with res_valid = 1 and res_taken != res_pred sets redirect_valid and flush high for exactly the following cycle. redirect_pc is then res_target if res_taken = 1, or res_pc + 4 otherwise. A resolution that agrees with its prediction raises neither signal.
- R7: When a mispredicting resolution and a valid instruction arrive in the same cycle, the instruction gets no prediction: out_valid stays 0 and cnt_pred does not count it.
- R8: cnt_pred counts the issued branch predictions and cnt_mispred counts the mispredicting resolutions. Each holds at 2^CNT_W - 1 once it reaches that value.
- R9: Outputs appear one clock after their inputs. out_valid is 1 only for a cycle whose in_valid was 1, and out_taken is 0 whenever out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = always not taken, 1 = backward taken / forward not taken |
| in_valid | input | 1 | An instruction is presented |
| in_is_branch | input | 1 | The instruction is a conditional branch |
| in_pc | input | ADDR_W | Address of the instruction |
| in_target | input | ADDR_W | Branch target address |
| in_hint | input | 2 | 00 none, 01 force not taken, 10 force taken, 11 none |
| res_valid | input | 1 | A branch resolution is presented |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| res_pred | input | 1 | Prediction that was issued for that branch |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_target | input | ADDR_W | Target of the resolved branch |
| out_valid | output | 1 | Prediction outputs are valid |
| out_taken | output | 1 | Predicted taken |
| out_next | output | ADDR_W | Predicted next fetch address |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | ADDR_W | Corrected fetch address |
| flush | output | 1 | Discard younger in-flight instructions |
| cnt_pred | output | CNT_W | Saturating count of issued branch predictions |
| cnt_mispred | output | CNT_W | Saturating count of mispredictions |

## Verification
A new prediction and a mispredict redirect can land in the same cycle. When they do, the redirect must win: the prediction is suppressed and left out of the count. The bench provokes this with a directed case in which both inputs are valid in one cycle. Random runs also raise res_valid and in_valid together often, with res_pred drawn independently of res_taken. The result is judged by comparing out_valid, redirect_valid and cnt_pred against a bench model that applies the same priority rule.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    HINT_NONE = 2'b00,
    HINT_NT   = 2'b01,
    HINT_T    = 2'b10,
    HINT_RSVD = 2'b11
  } hint_e;

  typedef enum logic {
    POL_SEQ = 1'b0,
    POL_DIR = 1'b1
  } policy_e;
endpackage

// File: rtl/sbp_decide.sv
module sbp_decide import sbp_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              is_branch,
  input  logic              mode,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  input  logic [1:0]        hint,
  output logic              taken,
  output logic [ADDR_W-1:0] next
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  hint_e   hint_c;
  policy_e pol_c;
  logic    backward;
  logic    rule_taken;

  assign hint_c   = hint_e'(hint);
  assign pol_c    = policy_e'(mode);
  // equal target counts as backward (a self loop)
  assign backward = (target <= pc);

  always_comb begin
    rule_taken = (pol_c == POL_DIR) ? backward : 1'b0;
    case (hint_c)
      HINT_T:  taken = is_branch;
      HINT_NT: taken = 1'b0;
      default: taken = is_branch & rule_taken;
    endcase
    next = taken ? target : pc + STEP;
  end
endmodule

// File: rtl/sbp_resolve.sv
module sbp_resolve #(
  parameter int ADDR_W = 32
) (
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic              res_pred,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic [ADDR_W-1:0] res_target,
  output logic              wrong,
  output logic [ADDR_W-1:0] fix_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  assign wrong  = res_valid & (res_taken ^ res_pred);
  assign fix_pc = res_taken ? res_target : res_pc + STEP;
endmodule

// File: rtl/sbp_satcnt.sv
module sbp_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                      value <= '0;
    else if (inc && value != TOP) value <= value + W'(1);
  end
endmodule

// File: rtl/static_branch_guess.sv
module static_branch_guess #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              in_valid,
  input  logic              in_is_branch,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [ADDR_W-1:0] in_target,
  input  logic [1:0]        in_hint,
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic              res_pred,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic [ADDR_W-1:0] res_target,
  output logic              out_valid,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_next,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              flush,
  output logic [CNT_W-1:0]  cnt_pred,
  output logic [CNT_W-1:0]  cnt_mispred
);
  localparam int NCNT = 2;

  logic              guess_taken;
  logic [ADDR_W-1:0] guess_next;
  logic              wrong;
  logic [ADDR_W-1:0] fix_pc;
  logic              issue;
  logic [NCNT-1:0]   cnt_inc;
  logic [CNT_W-1:0]  cnt_val [NCNT];

  sbp_decide #(.ADDR_W(ADDR_W)) u_decide (
    .is_branch (in_is_branch),
    .mode      (mode),
    .pc        (in_pc),
    .target    (in_target),
    .hint      (in_hint),
    .taken     (guess_taken),
    .next      (guess_next)
  );

  sbp_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .res_valid  (res_valid),
    .res_taken  (res_taken),
    .res_pred   (res_pred),
    .res_pc     (res_pc),
    .res_target (res_target),
    .wrong      (wrong),
    .fix_pc     (fix_pc)
  );

  // a redirect kills the wrong-path instruction arriving alongside it
  assign issue = in_valid & ~wrong;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_taken      <= 1'b0;
      out_next       <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      out_valid      <= issue;
      out_taken      <= issue & guess_taken;
      if (issue) out_next <= guess_next;
      redirect_valid <= wrong;
      if (wrong) redirect_pc <= fix_pc;
    end
  end

  assign flush = redirect_valid;

  assign cnt_inc[0] = issue & in_is_branch;
  assign cnt_inc[1] = wrong;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    sbp_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (cnt_inc[g]),
      .value (cnt_val[g])
    );
  end

  assign cnt_pred    = cnt_val[0];
  assign cnt_mispred = cnt_val[1];
endmodule

// File: rtl/static_branch_guess_chk.sv
module static_branch_guess_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_is_branch,
  input logic [ADDR_W-1:0] in_pc,
  input logic [ADDR_W-1:0] in_target,
  input logic              res_valid,
  input logic              res_taken,
  input logic              res_pred,
  input logic              out_valid,
  input logic              out_taken,
  input logic [ADDR_W-1:0] out_next,
  input logic              redirect_valid,
  input logic [CNT_W-1:0]  cnt_pred
);
  AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_taken) |-> out_next == $past(in_pc) + ADDR_W'(4)); // R2
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    out_taken |-> out_next == $past(in_target)); // R3
  AST_NONBRANCH_NT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(in_is_branch)) |-> !out_taken); // R5
  AST_REDIRECT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> ($past(res_valid) && $past(res_taken) != $past(res_pred))); // R6
  AST_KILL_PRED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !redirect_valid); // R7
  AST_CNT_MONO: assert property (@(posedge clk) disable iff (rst)
    cnt_pred >= $past(cnt_pred)); // R8
  AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R9
  AST_TAKEN_GATED: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_taken); // R9
endmodule

bind static_branch_guess static_branch_guess_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_is_branch   (in_is_branch),
  .in_pc          (in_pc),
  .in_target      (in_target),
  .res_valid      (res_valid),
  .res_taken      (res_taken),
  .res_pred       (res_pred),
  .out_valid      (out_valid),
  .out_taken      (out_taken),
  .out_next       (out_next),
  .redirect_valid (redirect_valid),
  .cnt_pred       (cnt_pred)
);

// File: tb/sim_static_branch_guess.sv
`timescale 1ns/1ps
module sim_static_branch_guess;
  localparam int AW = 32;
  localparam int CW = 6;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0;
  logic in_valid = 1'b0, in_is_branch = 1'b0;
  logic [AW-1:0] in_pc = '0, in_target = '0;
  logic [1:0] in_hint = 2'b00;
  logic res_valid = 1'b0, res_taken = 1'b0, res_pred = 1'b0;
  logic [AW-1:0] res_pc = '0, res_target = '0;
  logic out_valid, out_taken, redirect_valid, flush;
  logic [AW-1:0] out_next, redirect_pc;
  logic [CW-1:0] cnt_pred, cnt_mispred;

  always #10 clk = ~clk;

  static_branch_guess #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid),
    .in_is_branch(in_is_branch), .in_pc(in_pc), .in_target(in_target),
    .in_hint(in_hint), .res_valid(res_valid), .res_taken(res_taken),
    .res_pred(res_pred), .res_pc(res_pc), .res_target(res_target),
    .out_valid(out_valid), .out_taken(out_taken), .out_next(out_next),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .flush(flush),
    .cnt_pred(cnt_pred), .cnt_mispred(cnt_mispred)
  );

  int n_chk = 0, n_bad = 0;
  bit pending = 0;
  logic e_ov, e_tk, e_rv;
  logic [AW-1:0] e_nx, e_rpc;
  logic [CW-1:0] e_cp = '0, e_cm = '0;
  string tk_tag;

  function automatic logic model_taken(logic md, logic br, logic [AW-1:0] pc,
                                       logic [AW-1:0] tg, logic [1:0] h);
    if (!br) return 1'b0;
    if (h == 2'b10) return 1'b1;
    if (h == 2'b01) return 1'b0;
    return md ? (tg <= pc) : 1'b0;
  endfunction

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_pending();
    if (!pending) return;
    chk(e_ov ? "R9 out_valid" : "R7/R9 out_valid suppressed", AW'(out_valid), AW'(e_ov));
    chk({tk_tag, " out_taken"}, AW'(out_taken), AW'(e_tk));
    if (e_ov) chk({tk_tag, " out_next"}, out_next, e_nx);
    chk("R6 redirect_valid", AW'(redirect_valid), AW'(e_rv));
    chk("R6 flush", AW'(flush), AW'(e_rv));
    if (e_rv) chk("R6 redirect_pc", redirect_pc, e_rpc);
    chk("R8 cnt_pred", AW'(cnt_pred), AW'(e_cp));
    chk("R8 cnt_mispred", AW'(cnt_mispred), AW'(e_cm));
  endtask

  task automatic step(logic md, logic v, logic br, logic [AW-1:0] pc,
                      logic [AW-1:0] tg, logic [1:0] h, logic rv, logic rt,
                      logic rp, logic [AW-1:0] rpc, logic [AW-1:0] rtg);
    logic kill, t;
    @(negedge clk);
    compare_pending();
    mode = md; in_valid = v; in_is_branch = br; in_pc = pc; in_target = tg;
    in_hint = h; res_valid = rv; res_taken = rt; res_pred = rp;
    res_pc = rpc; res_target = rtg;
    kill = rv && (rt != rp);
    t = model_taken(md, br, pc, tg, h);
    e_ov = v && !kill;
    e_tk = e_ov && t;
    e_nx = t ? tg : pc + 32'd4;
    e_rv = kill;
    e_rpc = rt ? rtg : rpc + 32'd4;
    if (e_ov && br && e_cp != CMAX) e_cp = e_cp + 1'b1;
    if (kill && e_cm != CMAX) e_cm = e_cm + 1'b1;
    if (!br) tk_tag = "R5";
    else if (h == 2'b01 || h == 2'b10) tk_tag = "R4";
    else if (md) tk_tag = "R3";
    else tk_tag = "R2";
    pending = 1;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is held
    chk("R1 out_valid", AW'(out_valid), '0);
    chk("R1 redirect_valid", AW'(redirect_valid), '0);
    chk("R1 flush", AW'(flush), '0);
    chk("R1 cnt_pred", AW'(cnt_pred), '0);
    chk("R1 cnt_mispred", AW'(cnt_mispred), '0);
    rst = 1'b0;
    // idle first cycle after reset (R1, R9)
    step(0, 0, 0, 32'h0, 32'h0, 2'b00, 0, 0, 0, 32'h0, 32'h0);
    // R2: sequential policy ignores direction
    step(0, 1, 1, 32'h100, 32'h80, 2'b00, 0, 0, 0, 0, 0);
    step(0, 1, 1, 32'h100, 32'h200, 2'b11, 0, 0, 0, 0, 0);
    // R3: direction policy, backward / forward / equal
    step(1, 1, 1, 32'h400, 32'h3F0, 2'b00, 0, 0, 0, 0, 0);
    step(1, 1, 1, 32'h400, 32'h500, 2'b00, 0, 0, 0, 0, 0);
    step(1, 1, 1, 32'h400, 32'h400, 2'b00, 0, 0, 0, 0, 0);
    // R4: hint overrides, reserved code ignored
    step(0, 1, 1, 32'h40, 32'h90, 2'b10, 0, 0, 0, 0, 0);
    step(1, 1, 1, 32'h90, 32'h40, 2'b01, 0, 0, 0, 0, 0);
    step(1, 1, 1, 32'h90, 32'h40, 2'b11, 0, 0, 0, 0, 0);
    // R5: non-branch ignores hint and target
    step(1, 1, 0, 32'h90, 32'h40, 2'b10, 0, 0, 0, 0, 0);
    // R6: both mispredict directions, then a correct resolution
    step(0, 0, 0, 0, 0, 2'b00, 1, 1, 0, 32'h200, 32'h120);
    step(0, 0, 0, 0, 0, 2'b00, 1, 0, 1, 32'h300, 32'h280);
    step(0, 0, 0, 0, 0, 2'b00, 1, 1, 1, 32'h300, 32'h280);
    // R7: redirect and new prediction in one cycle
    step(1, 1, 1, 32'h500, 32'h4F0, 2'b00, 1, 1, 0, 32'h600, 32'h700);
    step(1, 1, 1, 32'h500, 32'h4F0, 2'b00, 1, 1, 1, 32'h600, 32'h700);
    // random mix; also drives counters into saturation (R8)
    for (int i = 0; i < 800; i++) begin
      logic [AW-1:0] pc, tg;
      pc = {$urandom_range(0, 255), 2'b00};
      case ($urandom_range(0, 3))
        0: tg = pc;
        1: tg = pc - {$urandom_range(1, 64), 2'b00};
        default: tg = pc + {$urandom_range(1, 64), 2'b00};
      endcase
      step(1'($urandom), ($urandom_range(0, 9) != 0), ($urandom_range(0, 3) != 0),
           pc, tg, 2'($urandom), ($urandom_range(0, 2) == 0), 1'($urandom),
           1'($urandom), {$urandom_range(0, 255), 2'b00}, {$urandom_range(0, 255), 2'b00});
    end
    step(0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare_pending();
    // R8: both counters must now sit at their ceiling
    chk("R8 cnt_pred saturated", AW'(cnt_pred), AW'(CMAX));
    chk("R8 cnt_mispred saturated", AW'(cnt_mispred), AW'(CMAX));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule